// File: doc/BRIEF.md
# Buffered-Compare Interval Timer

This block is a 16-bit interval timer that produces a periodic event. Software writes a compare value and a control word through a small register write port. The counter advances on single-cycle count ticks. A tick comes either from a power-of-two prescaler of the system clock or from rising edges of a synchronized external event input. A control bit chooses between the two.

When the timer is enabled, the counter rests at FFFFH until the first count tick. That tick wraps the counter to 0000H, inverts the timer output and loads the compare value into a shadow buffer. From then on the counter is compared against the buffer, not against the programmed register. On a match, the next tick clears the counter, inverts the output, pulses the match interrupt and reloads the buffer. A compare value written during a period therefore takes effect only from the following period.

Top module: `interval_timer`

## Requirements
- R1: After reset, and one cycle after the timer stops running, `count_val` reads FFFFH, `tmr_out` is 0 and `match_irq` is 0.
- R2: The first count tick after the timer is enabled sets the counter to 0000H and inverts `tmr_out`. It does not raise `match_irq`.
- R3: After the start tick, each further count tick raises the counter by one while it differs from the buffered compare value. Without a tick the counter holds its value.
- R4: On a tick that finds the counter equal to the buffered compare value, the counter clears to 0000H, `tmr_out` inverts and `match_irq` is high for that one cycle.
- R5: Successive match pulses are (compare value + 1) count ticks apart. A compare value of 0 gives a match on every tick.
- R6: A compare value written while the timer runs does not change the current period. It is loaded into the buffer at the next match and governs the period after it.
- R7: With the source bit at 0 and clock select k (0 to 7), a count tick occurs every 2^k system clocks. The first tick comes 2^k clocks after the enabling write.
- R8: With the source bit at 1, each rising edge of `ext_evt_in` gives exactly one count tick, however long the input stays high. The counter changes on the third clock edge after the input rises. The internal prescaler has no effect in this setting.
- R9: The timer runs only when the enable bit is 1 and the mode field is 000. Any other mode value keeps the idle state of R1.
- R10: A write with `cfg_addr`=1 sets the compare value. A write with `cfg_addr`=0 sets the control word: bit 0 enable, bit 1 source (1 = external), bits 4:2 clock select k, bits 7:5 mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 selects the control word, 1 selects the compare value |
| cfg_wdata | input | 16 | Write data |
| ext_evt_in | input | 1 | Asynchronous external event input |
| tmr_out | output | 1 | Timer output, inverts at start and at every match |
| match_irq | output | 1 | One-cycle compare-match pulse |
| count_val | output | 16 | Current counter value |

## Verification
The hardest condition to reach from the ports is a compare value that changes in the middle of a period. The bench has to land the write after the buffer was loaded and before the match. It does this by counting clock edges from the enabling write with the prescaler set to divide by one. That makes the write cycle exact, so the bench can show that the old period still ends on the old value and that the new value governs the next period. External counting is reached the same way: the bench drives edges whose high time is longer than one cycle and checks for exactly one step per edge, three edges after the rise.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
    localparam int CKS_W  = 3;
    localparam int MODE_W = 3;

    localparam int BIT_EN   = 0;
    localparam int BIT_SRC  = 1;
    localparam int CKS_LSB  = 2;
    localparam int MODE_LSB = CKS_LSB + CKS_W;

    typedef struct packed {
        logic              en;
        logic              ext_src;
        logic [CKS_W-1:0]  cks;
        logic [MODE_W-1:0] mode;
    } ctrl_t;
endpackage

// File: rtl/itmr_tick_gen.sv
module itmr_tick_gen #(
    parameter int CKS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ext_src,
    input  logic [CKS_W-1:0] cks,
    input  logic             ext_in,
    output logic             tick
);
    localparam int PRE_W = (1 << CKS_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] presc;
        logic [2:0]       sync;
    } st_t;

    st_t st_d, st_q;
    logic [PRE_W:0]   one_hot;
    logic [PRE_W-1:0] mask;
    logic             int_tick;
    logic             ext_edge;

    always_comb begin
        one_hot  = (PRE_W+1)'(1) << cks;
        mask     = PRE_W'(one_hot - 1'b1);
        int_tick = (st_q.presc & mask) == mask;
        ext_edge = st_q.sync[1] & ~st_q.sync[2];
        tick     = run & (ext_src ? ext_edge : int_tick);

        st_d      = st_q;
        st_d.sync = {st_q.sync[1:0], ext_in};
        if (!run || ext_src) begin
            st_d.presc = '0;
        end else begin
            st_d.presc = st_q.presc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: an edge detector never fires on two consecutive cycles
    p_ext_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ext_src) |=> !(tick && ext_src));

    // R7: divide-by-one gives a tick in every running cycle
    p_div1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ext_src && cks == '0 && $past(run && !ext_src)) |-> tick);
endmodule

// File: rtl/itmr_core.sv
module itmr_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt,
    output logic             tmr_out,
    output logic             irq
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp_buf;
        logic             started;
        logic             out;
        logic             irq;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (!run) begin
            st_d.cnt     = '1;
            st_d.out     = 1'b0;
            st_d.started = 1'b0;
        end else if (tick) begin
            if (!st_q.started) begin
                st_d.started = 1'b1;
                st_d.cnt     = '0;
                st_d.out     = ~st_q.out;
                st_d.cmp_buf = cmp_val;
            end else if (st_q.cnt == st_q.cmp_buf) begin
                st_d.cnt     = '0;
                st_d.out     = ~st_q.out;
                st_d.irq     = 1'b1;
                st_d.cmp_buf = cmp_val;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cnt <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt     = st_q.cnt;
    assign tmr_out = st_q.out;
    assign irq     = st_q.irq;

    // R1: stopped timer settles to the idle outputs
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '1 && !tmr_out && !irq));

    // R2: start tick wraps to zero, inverts the pin, no interrupt
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !st_q.started) |=> (cnt == '0 && !irq && tmr_out != $past(tmr_out)));

    // R3: no tick, no movement
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && $past(run)) |=> $stable(cnt));

    // R4: an interrupt comes with a cleared counter and an inverted pin
    p_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cnt == '0 && tmr_out != $past(tmr_out)));

    // R6: the buffer only changes on start or match ticks
    p_buf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick || (st_q.started && st_q.cnt != st_q.cmp_buf)) |=> $stable(st_q.cmp_buf));
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_addr,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             ext_evt_in,
    output logic             tmr_out,
    output logic             match_irq,
    output logic [CNT_W-1:0] count_val
);
    import itmr_pkg::*;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] cmp;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  run;
    logic  tick;

    always_comb begin
        regs_d = regs_q;
        if (cfg_we) begin
            if (cfg_addr) begin
                regs_d.cmp = cfg_wdata;
            end else begin
                regs_d.ctrl.en      = cfg_wdata[BIT_EN];
                regs_d.ctrl.ext_src = cfg_wdata[BIT_SRC];
                regs_d.ctrl.cks     = cfg_wdata[CKS_LSB +: CKS_W];
                regs_d.ctrl.mode    = cfg_wdata[MODE_LSB +: MODE_W];
            end
        end
        run = regs_q.ctrl.en && (regs_q.ctrl.mode == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q     <= '0;
            regs_q.cmp <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    itmr_tick_gen #(.CKS_W(CKS_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .ext_src (regs_q.ctrl.ext_src),
        .cks     (regs_q.ctrl.cks),
        .ext_in  (ext_evt_in),
        .tick    (tick)
    );

    itmr_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (tick),
        .cmp_val (regs_q.cmp),
        .cnt     (count_val),
        .tmr_out (tmr_out),
        .irq     (match_irq)
    );

    // R9: a non-zero mode field keeps the counter idle
    p_mode_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.ctrl.mode != '0) |=> (count_val == '1 && !match_irq));
endmodule

// File: tb/interval_timer_bench.sv
module interval_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        ext_evt_in = 1'b0;
    logic        tmr_out;
    logic        match_irq;
    logic [15:0] count_val;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    interval_timer u_interval_timer (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ext_evt_in(ext_evt_in), .tmr_out(tmr_out),
        .match_irq(match_irq), .count_val(count_val)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic a, logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic stop_timer();
        wr(1'b0, 16'h0000);
        step(2);
    endtask

    task automatic t_reset();
        step(1);
        chk("R1 reset count", count_val, 16'hFFFF);
        chk("R1 reset out", tmr_out, 0);
        chk("R1 reset irq", match_irq, 0);
    endtask

    task automatic t_start_match();
        wr(1'b1, 16'd3);
        wr(1'b0, 16'h0001);
        chk("R2 before tick", count_val, 16'hFFFF);
        step(1);
        chk("R2 start count", count_val, 0);
        chk("R2 start out", tmr_out, 1);
        chk("R2 start no irq", match_irq, 0);
        step(1);
        chk("R3 step", count_val, 1);
        step(2);
        chk("R3 at buffer", count_val, 3);
        chk("R3 no early irq", match_irq, 0);
        step(1);
        chk("R4 clear", count_val, 0);
        chk("R4 irq", match_irq, 1);
        chk("R4 out toggle", tmr_out, 0);
        step(1);
        chk("R4 irq one cycle", match_irq, 0);
        chk("R4 restart", count_val, 1);
        wr(1'b0, 16'h0000);
        step(1);
        chk("R1 stop count", count_val, 16'hFFFF);
        chk("R1 stop out", tmr_out, 0);
        step(1);
    endtask

    task automatic measure(string tag, int expected);
        int n = 0;
        int guard = 0;
        while (match_irq !== 1'b1 && guard < 2000) begin step(1); guard++; end
        step(1); n = 1;
        while (match_irq !== 1'b1 && n < 2000) begin step(1); n++; end
        chk(tag, n, expected);
    endtask

    task automatic t_periods();
        wr(1'b1, 16'd9);
        wr(1'b0, 16'h0001);
        measure("R5 period cmp9 k0", 10);
        stop_timer();
        wr(1'b1, 16'd4);
        wr(1'b0, 16'h0009);
        step(3);
        chk("R7 first tick not yet", count_val, 16'hFFFF);
        step(1);
        chk("R7 first tick k2", count_val, 0);
        step(4);
        chk("R7 second tick k2", count_val, 1);
        measure("R7 period cmp4 k2", 20);
        stop_timer();
    endtask

    task automatic t_cmp_zero();
        wr(1'b1, 16'd0);
        wr(1'b0, 16'h0001);
        step(1);
        chk("R2 start cmp0", tmr_out, 1);
        step(1);
        chk("R5 cmp0 irq", match_irq, 1);
        chk("R5 cmp0 out", tmr_out, 0);
        step(1);
        chk("R5 cmp0 irq again", match_irq, 1);
        chk("R5 cmp0 out again", tmr_out, 1);
        stop_timer();
    endtask

    task automatic t_reload();
        wr(1'b1, 16'd3);
        wr(1'b0, 16'h0001);
        step(2);
        chk("R6 pre-write", count_val, 1);
        wr(1'b1, 16'd6);
        chk("R6 after write", count_val, 2);
        step(1);
        chk("R6 old value reached", count_val, 3);
        step(1);
        chk("R6 old period ends", match_irq, 1);
        step(6);
        chk("R6 new value reached", count_val, 6);
        chk("R6 no irq at 6", match_irq, 0);
        step(1);
        chk("R6 new period ends", match_irq, 1);
        stop_timer();
    endtask

    task automatic pulse(int high);
        ext_evt_in = 1'b1;
        step(high);
        ext_evt_in = 1'b0;
        step(4);
    endtask

    task automatic t_external();
        wr(1'b1, 16'd2);
        wr(1'b0, 16'h0003);
        step(10);
        chk("R8 internal ignored", count_val, 16'hFFFF);
        ext_evt_in = 1'b1;
        step(2);
        chk("R8 latency not yet", count_val, 16'hFFFF);
        step(1);
        chk("R8 start on edge", count_val, 0);
        step(6);
        chk("R8 level counts once", count_val, 0);
        ext_evt_in = 1'b0;
        step(4);
        pulse(1);
        chk("R8 short pulse", count_val, 1);
        pulse(5);
        chk("R8 long pulse", count_val, 2);
        ext_evt_in = 1'b1;
        step(3);
        chk("R8 ext match irq", match_irq, 1);
        chk("R8 ext match clear", count_val, 0);
        ext_evt_in = 1'b0;
        step(3);
        stop_timer();
    endtask

    task automatic t_mode();
        wr(1'b1, 16'd2);
        wr(1'b0, 16'h0021);
        step(20);
        chk("R9 mode count", count_val, 16'hFFFF);
        chk("R9 mode out", tmr_out, 0);
        chk("R9 mode irq", match_irq, 0);
        wr(1'b0, 16'h0001);
        step(1);
        chk("R10 enable bit runs", count_val, 0);
        stop_timer();
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        t_reset();
        t_start_match();
        t_periods();
        t_cmp_zero();
        t_reload();
        t_external();
        t_mode();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule